// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets logic on a synchronous clock read and write an external, unclocked static RAM that holds 8192 bytes. The host hands over one request at a time through a request/ready handshake. Each request carries a 13-bit address, a write flag and, for writes, a data byte. Read results come back on a data output together with a one-cycle valid strobe.

On the memory side the controller drives three active-low strobes: select, output enable and write enable. It also drives the address bus. The bidirectional data bus is split into an outgoing value, an incoming value and a drive enable, so that the pad cell can stay outside the block.

Every interval the memory needs is given in picoseconds. This covers access time, strobe width, setups, cycle times and bus release. Each interval becomes a whole number of clock cycles: the value is rounded up, and never falls below one cycle. The same RTL therefore serves any clock rate once the clock period parameter is set. A write can be run with output enable held high, which allows a shorter strobe, or with output enable held low.

Top module: `sram_ctl`

## Requirements
- R1: After a synchronous active-low reset, and whenever no access is in progress, `ready` is 1. The outputs `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1, `sram_dq_oe` is 0 and `rd_valid` is 0.
- R2: A request is accepted on a rising edge where `req` and `ready` are both 1. `ready` is then 0 from the next cycle until the access, including its recovery, has finished. A request presented while `ready` is 0 has no effect.
- R3: A read drives `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for ceil(max(10 ns address/select access, 6 ns output-enable access) / clock period) cycles. The bus is sampled at the edge that ends that window, and `rd_data` then equals the byte stored at the address.
- R4: `rd_valid` is 1 for exactly one cycle, the cycle after the sampling edge of a read. It is never 1 because of a write.
- R5: A write holds `sram_ce_n` and `sram_we_n` both 0 for ceil(max(9 ns address and select setup, 8 ns strobe width, 7 ns data setup) / period) cycles. The data is taken when the first of the two rises, and a later read of that address returns the byte.
- R6: In the default write mode `sram_oe_n` stays 1 through the write. `sram_dq_oe` is 1 only while `sram_ce_n` and `sram_we_n` are both 0.
- R7: `sram_dq_oe` never rises while the memory may still be driving the bus. The memory may drive the bus during a read and for 5 ns after output enable rises; if a pending release window is still open, the write waits in a turnaround state first.
- R8: `sram_addr` does not change while `sram_ce_n` stays 0 from one cycle to the next.
- R9: A read keeps `ready` low for ceil(10 ns read cycle / period) cycles or the access count, whichever is larger. A write keeps `ready` low for the strobe count plus any shortfall against ceil(10 ns write cycle / period). Every count is at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller can accept a request |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | 13 | Memory address bus |
| sram_dq_out | output | 8 | Byte to drive on the data bus |
| sram_dq_in | input | 8 | Byte seen on the data bus |
| sram_dq_oe | output | 1 | Enable for the controller's data driver |

## Verification
A sequencer state or interval counter that is off by one shows at the ports in the same access. `ready` returns a cycle early or late, and the reference model flags the mismatch on that clock. A sampling point that is too early picks up the deliberately wrong byte that the memory model presents before its access time has elapsed, so `rd_data` is wrong on the `rd_valid` cycle. A strobe that is too short, an address that moves under a select, or a driver that turns on during the memory's release window is caught by the memory model's own timing checks on the edge where it happens. Any corrupted write also resurfaces as a wrong byte on the next read of that address.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and constant functions for the SRAM controller.
// Assumes all timing values are given in picoseconds and are non-negative.
package sram_ctl_pkg;

    // Sequencer states of the controller.
    typedef enum logic [2:0] {
        ST_IDLE,   // deselected, accepting requests
        ST_RD,     // read strobes active, waiting for access time
        ST_RREC,   // read recovery to meet the read cycle time
        ST_WTURN,  // waiting for the memory to release the data bus
        ST_WSTB,   // write strobes active
        ST_WREC    // write recovery to meet the write cycle time
    } seq_st_e;

    // Whole clock cycles covering an interval, rounded up, minimum one.
    function automatic int unsigned ceil_cyc(input int unsigned ps, input int unsigned per_ps);
        int unsigned c;
        c = (ps + per_ps - 1) / per_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Shortfall of a cycle-time count against an already spent count.
    function automatic int unsigned rest_u(input int unsigned total, input int unsigned spent);
        return (total > spent) ? total - spent : 0;
    endfunction

endpackage

// File: rtl/sram_ctl_delay.sv
`timescale 1ns/1ps
// Loadable down-counter used for every timed interval of the controller.
// A load of N gives N cycles with count N..1, then the count rests at 0.
// Assumes load_val is non-zero whenever load is asserted.
module sram_ctl_delay #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - CNT_W'(1);
    end

endmodule

// File: rtl/sram_ctl_datapath.sv
`timescale 1ns/1ps
// Holds the address and write byte of the accepted request, and samples
// read data from the bus at the end of the access window.
// Assumes accept and capture are never high in the same cycle.
module sram_ctl_datapath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Latch the request fields so the memory sees them stable for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus at the end of the access window and raise a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= dq_in;
        end
    end

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
// Synchronous controller for an external asynchronous 8-bit static RAM.
// Sequences select, output enable and write enable, holds address and data
// stable, turns the data bus around, and samples read data. All intervals
// are rounded up to whole cycles of CLK_PS. One request is in flight at a time.
// Assumes the data-bus pad is outside; dq_in must be a synchronous-safe
// view of the bus at each sampling edge.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PS        = 8000,
    parameter int T_RCYC_PS     = 10000,
    parameter int T_ACC_PS      = 10000,
    parameter int T_OEACC_PS    = 6000,
    parameter int T_WCYC_PS     = 10000,
    parameter int T_ASET_PS     = 9000,
    parameter int T_CSET_PS     = 9000,
    parameter int T_WPLO_PS     = 9000,
    parameter int T_WPHI_PS     = 8000,
    parameter int T_DSET_PS     = 7000,
    parameter int T_OEREL_PS    = 5000,
    parameter int T_WEREL_PS    = 6000,
    parameter bit WRITE_OE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);

    // Cycle counts derived from the picosecond timings.
    localparam int unsigned RD_CYC   = max_u(ceil_cyc(T_ACC_PS, CLK_PS), ceil_cyc(T_OEACC_PS, CLK_PS));
    localparam int unsigned RREC_CYC = rest_u(ceil_cyc(T_RCYC_PS, CLK_PS), RD_CYC);
    localparam int unsigned REL_CYC  = ceil_cyc(T_OEREL_PS, CLK_PS);
    localparam int unsigned DRV_DLY  = WRITE_OE_HIGH ? 0 : ceil_cyc(T_WEREL_PS, CLK_PS);
    localparam int unsigned WP_CYC   = WRITE_OE_HIGH ? ceil_cyc(T_WPHI_PS, CLK_PS)
                                                     : ceil_cyc(T_WPLO_PS, CLK_PS);
    localparam int unsigned SETUP_CYC = max_u(ceil_cyc(T_ASET_PS, CLK_PS), ceil_cyc(T_CSET_PS, CLK_PS));
    localparam int unsigned STB_CYC  = max_u(SETUP_CYC, max_u(WP_CYC, DRV_DLY + ceil_cyc(T_DSET_PS, CLK_PS)));
    localparam int unsigned WREC_CYC = rest_u(ceil_cyc(T_WCYC_PS, CLK_PS), STB_CYC);
    localparam int unsigned MAX_CYC  = max_u(max_u(RD_CYC, RREC_CYC), max_u(max_u(STB_CYC, WREC_CYC), REL_CYC));
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_V       = CNT_W'(RD_CYC);
    localparam logic [CNT_W-1:0] RREC_V     = CNT_W'(RREC_CYC);
    localparam logic [CNT_W-1:0] REL_V      = CNT_W'(REL_CYC);
    localparam logic [CNT_W-1:0] STB_V      = CNT_W'(STB_CYC);
    localparam logic [CNT_W-1:0] WREC_V     = CNT_W'(WREC_CYC);
    localparam logic [CNT_W-1:0] DRV_LAST_V = CNT_W'(STB_CYC - DRV_DLY);
    localparam logic [CNT_W-1:0] ONE_V      = CNT_W'(1);

    seq_st_e          st, st_nx;
    logic             accept;
    logic             capture;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic [CNT_W-1:0] t_cnt;
    logic             t_last;
    logic [CNT_W-1:0] rel_cnt;

    // Interval timer for the current phase.
    sram_ctl_delay #(.CNT_W(CNT_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .count    (t_cnt)
    );

    // Bus release timer, started when output enable rises at the end of a read.
    sram_ctl_delay #(.CNT_W(CNT_W)) u_release_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (capture),
        .load_val (REL_V),
        .count    (rel_cnt)
    );

    // Request latching and read sampling.
    sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (sram_dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_out),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign t_last  = (t_cnt == ONE_V);
    assign capture = (st == ST_RD) && t_last;

    // Next-state and timer-load decisions of the sequencer.
    always_comb begin
        st_nx  = st;
        t_load = 1'b0;
        t_val  = '0;
        accept = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (req_wr) begin
                        if (rel_cnt > ONE_V) begin
                            st_nx = ST_WTURN;
                        end else begin
                            st_nx  = ST_WSTB;
                            t_load = 1'b1;
                            t_val  = STB_V;
                        end
                    end else begin
                        st_nx  = ST_RD;
                        t_load = 1'b1;
                        t_val  = RD_V;
                    end
                end
            end
            ST_RD: begin
                if (t_last) begin
                    if (RREC_CYC > 0) begin
                        st_nx  = ST_RREC;
                        t_load = 1'b1;
                        t_val  = RREC_V;
                    end else begin
                        st_nx = ST_IDLE;
                    end
                end
            end
            ST_RREC: begin
                if (t_last) st_nx = ST_IDLE;
            end
            ST_WTURN: begin
                if (rel_cnt <= ONE_V) begin
                    st_nx  = ST_WSTB;
                    t_load = 1'b1;
                    t_val  = STB_V;
                end
            end
            ST_WSTB: begin
                if (t_last) begin
                    if (WREC_CYC > 0) begin
                        st_nx  = ST_WREC;
                        t_load = 1'b1;
                        t_val  = WREC_V;
                    end else begin
                        st_nx = ST_IDLE;
                    end
                end
            end
            ST_WREC: begin
                if (t_last) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // Memory strobes and driver enable decoded from the registered state.
    always_comb begin
        ready      = (st == ST_IDLE);
        sram_ce_n  = !((st == ST_RD) || (st == ST_WSTB));
        sram_we_n  = !(st == ST_WSTB);
        sram_oe_n  = !((st == ST_RD) || ((st == ST_WSTB) && !WRITE_OE_HIGH));
        sram_dq_oe = (st == ST_WSTB) && (t_cnt <= DRV_LAST_V);
    end

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_ce_n && !sram_we_n));

    // R7
    drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (rel_cnt == '0));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

    // R3
    read_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && (sram_we_n || !WRITE_OE_HIGH)));

    // R4
    no_valid_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> !rd_valid);

endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference model of the host handshake,
// plus a timing-aware model of the asynchronous memory on the pins.
module tb_sram_ctl;

    localparam int CLK_NS = 8;

    function automatic int cdiv(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD   = mx(cdiv(10, CLK_NS), cdiv(6, CLK_NS));
    localparam int RREC = mx(cdiv(10, CLK_NS) - RD, 0);
    localparam int STB  = mx(mx(cdiv(9, CLK_NS), cdiv(8, CLK_NS)), cdiv(7, CLK_NS));
    localparam int WREC = mx(cdiv(10, CLK_NS) - STB, 0);
    localparam int HZ   = cdiv(5, CLK_NS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid;
    logic [7:0]  rd_data;
    logic        ce_n, oe_n, we_n, dq_oe;
    logic [12:0] maddr;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = '0;

    sram_ctl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .sram_ce_n(ce_n),
        .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_addr(maddr),
        .sram_dq_out(dq_out), .sram_dq_in(dq_in), .sram_dq_oe(dq_oe)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int acc_count = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    logic [7:0] ref_mem  [0:8191];
    logic [7:0] sram_arr [0:8191];
    initial begin
        for (int i = 0; i < 8192; i++) begin
            ref_mem[i]  = 8'(i) ^ 8'h3C;
            sram_arr[i] = 8'(i) ^ 8'h3C;
        end
    end

    // ---------------- reference model of the host side ----------------
    bit          exp_ready = 1'b1;
    bit          exp_rvalid = 1'b0;
    logic [7:0]  exp_rdata = '0;
    int          busy = 0, rd_left = 0, hz_left = 0;
    logic [12:0] raddr = '0;

    always @(posedge clk) begin
        bit s_rst, s_req, s_wr;
        logic [12:0] s_addr;
        logic [7:0]  s_wd;
        int h_pre;
        s_rst = rst_n; s_req = req; s_wr = req_wr; s_addr = req_addr; s_wd = req_wdata;
        if (!s_rst) begin
            exp_ready = 1; exp_rvalid = 0; busy = 0; rd_left = 0; hz_left = 0;
        end else begin
            exp_rvalid = 0;
            h_pre = hz_left;
            if (hz_left > 0) hz_left--;
            if (busy > 0) begin
                busy--;
                if (rd_left > 0) begin
                    rd_left--;
                    if (rd_left == 0) begin
                        exp_rvalid = 1;
                        exp_rdata  = ref_mem[raddr];
                        hz_left    = HZ;
                    end
                end
                if (busy == 0) exp_ready = 1;
            end else if (exp_ready && s_req) begin
                acc_count++;
                exp_ready = 0;
                if (s_wr) begin
                    ref_mem[s_addr] = s_wd;
                    busy = ((h_pre > 1) ? h_pre - 1 : 0) + STB + WREC;
                end else begin
                    raddr   = s_addr;
                    rd_left = RD;
                    busy    = RD + RREC;
                end
            end
        end
        #2;
        if (s_rst) begin
            chk(ready === exp_ready, "R2 R9 ready", int'(ready), int'(exp_ready));
            chk(rd_valid === exp_rvalid, "R4 rd_valid", int'(rd_valid), int'(exp_rvalid));
            if (exp_rvalid)
                chk(rd_data === exp_rdata, "R3 rd_data", int'(rd_data), int'(exp_rdata));
            if (exp_ready)
                chk({ce_n, we_n, oe_n, dq_oe} === 4'b1110, "R1 idle pins",
                    int'({ce_n, we_n, oe_n, dq_oe}), 4'hE);
        end
    end

    // ---------------- timing model of the memory ----------------
    logic        p_ce = 1, p_we = 1, p_oe = 1, p_doe = 0;
    logic [12:0] p_addr = '0;
    logic [7:0]  p_dout = '0;
    longint      t_ce = 0, t_addr = 0, t_we = 0, t_oe = 0, t_d = 0, t_rel = -100;

    always @(posedge clk) begin
        longint te;
        bit rd_now, rd_prev;
        #1;
        te = $time - 1;
        if (rst_n) begin
            rd_now  = !ce_n && !oe_n && we_n;
            rd_prev = !p_ce && !p_oe && p_we;
            // write ends on the first of select or write enable rising
            if (!p_ce && !p_we && (ce_n || we_n)) begin
                chk(te - t_we >= (p_oe ? 8 : 9), "R5 strobe width", int'(te - t_we), p_oe ? 8 : 9);
                chk(te - t_ce >= 9, "R5 select setup", int'(te - t_ce), 9);
                chk(te - t_addr >= 9, "R5 address setup", int'(te - t_addr), 9);
                chk(p_doe && (te - t_d >= 7), "R5 data setup", int'(te - t_d), 7);
                chk(p_oe === 1'b1, "R6 oe high in write", int'(p_oe), 1);
                sram_arr[p_addr] = p_dout;
            end
            if (!p_ce && !ce_n)
                chk(maddr === p_addr, "R8 address stable", int'(maddr), int'(p_addr));
            if (rd_prev && !rd_now) t_rel = te + 5;
            if (!we_n && p_we && !oe_n) t_rel = mx(int'(t_rel), int'(te + 6));
            if (dq_oe) begin
                chk(!(rd_now || te < t_rel), "R7 bus contention", int'(rd_now), 0);
                chk(!ce_n && !we_n, "R6 driver window", int'({ce_n, we_n}), 0);
            end
            if (ce_n !== p_ce && !ce_n) t_ce = te;
            if (maddr !== p_addr) t_addr = te;
            if (!we_n && p_we) t_we = te;
            if (!oe_n && p_oe) t_oe = te;
            if ((dq_oe && !p_doe) || (dq_oe && dq_out !== p_dout)) t_d = te;
            // value the bus carries at the next edge
            if (rd_now && (te + CLK_NS - t_ce >= 10) && (te + CLK_NS - t_addr >= 10)
                && (te + CLK_NS - t_oe >= 6))
                dq_in = sram_arr[maddr];
            else
                dq_in = ~sram_arr[maddr];
        end
        p_ce = ce_n; p_we = we_n; p_oe = oe_n; p_doe = dq_oe; p_addr = maddr; p_dout = dq_out;
    end

    // ---------------- stimulus ----------------
    task automatic op(input bit wr, input logic [12:0] a, input logic [7:0] d);
        int a0;
        a0 = acc_count;
        req = 1; req_wr = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (acc_count == a0);
        req = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ready, ce_n, we_n, oe_n, dq_oe, rd_valid} === 6'b111100, "R1 reset",
            int'({ready, ce_n, we_n, oe_n, dq_oe, rd_valid}), 6'h3C);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R5 writes at both address extremes and a mid pattern
        op(1, 13'h0000, 8'h11);
        op(1, 13'h1FFF, 8'h22);
        op(1, 13'h0AAA, 8'h5A);
        // R3 read back, plus a never-written address
        op(0, 13'h0000, 8'h00);
        op(0, 13'h1FFF, 8'h00);
        op(0, 13'h0AAA, 8'h00);
        op(0, 13'h1234, 8'h00);
        // R5 overwrite the same address, last write wins
        op(1, 13'h0005, 8'hC3);
        op(1, 13'h0005, 8'h3C);
        op(0, 13'h0005, 8'h00);
        // R7 read followed at once by write, then read
        op(0, 13'h0007, 8'h00);
        op(1, 13'h0007, 8'h77);
        op(0, 13'h0007, 8'h00);
        repeat (3) @(negedge clk);
        // R2 requests held high back to back; mixed pattern
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(lf[0], {(lf[7] ? 7'h7F : 7'h00), lf[13:8]}, lf[15:8] ^ 8'(k));
            if (lf[3] && lf[4]) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule